// File: doc/BRIEF.md
# Serial Flash Controller Register and FIFO Front End

This block is the 32-bit register slave that sits between a host bus and the frame sequencer of a serial flash controller. It holds the control word, the frame description and its upper count extension, and the interrupt enables. The sequencer reads all of these from configuration outputs. Two byte queues connect the two sides. The host fills a transmit queue that the sequencer drains one byte at a time. The sequencer fills a receive queue that the host drains. The receive queue holds twice as many bytes as the transmit queue.

The host reaches each queue through two data registers. One moves a single byte in bits 7:0. The other moves four bytes packed into one word, with the earliest byte in bits 7:0. Both registers act on the same queue. A status word reports queue levels, the sequencer's ready line and three sticky events. The host clears an event by writing one to its bit. The interrupt line is raised while any enabled status bit is set.

Top module: `qspi_bus_regs`

## Requirements
- R1: After synchronous reset every register reads zero, status reads 0x18 (TX space bit3 and RX empty bit4 set, ready input low) and the interrupt is low.
- R2: Control (0x00) keeps only bits 0, 1, 10, 13, 14, 15, 16 and 27:24, and other bits read zero. Frames (0x04) keeps all 32 bits. Interrupt enable (0x0C) keeps bits 5:0. Upper count (0x50) keeps bits 31:16. The total-count output joins the upper count with frames bits 15:0.
- R3: Bytes written to the byte transmit register (0x44, bits 7:0) reach the sequencer side in write order.
- R4: A write to the packed transmit register (0x4C) queues four bytes, bits 7:0 first. It is dropped whole if fewer than four places are free.
- R5: A read of the packed receive register (0x48) removes four bytes and returns them with the earliest in bits 7:0. A read of the byte receive register (0x40) removes one byte and returns it in bits 7:0.
- R6: The transmit queue holds TX_DEPTH bytes. Status bit5 is set while it is full, and byte writes to a full queue are dropped.
- R7: A byte read of an empty receive queue returns zero. A packed read with fewer than four bytes queued returns zero. In both cases nothing is removed.
- R8: A sequencer pulse of tx-done sets status bit0, and a pulse of rx-done sets bit1. The bits stay set until the host writes 1 to them at 0x10, and a 0 written to a bit leaves it unchanged.
- R9: Status bit2 (RX available) is set in the cycle after the receive queue holds at least 1 byte with control bit16 clear, or at least 4 bytes with bit16 set. It then stays set until cleared by writing 1.
- R10: The interrupt equals the OR over bits 5:0 of status ANDed with the enable register.
- R11: Status bit7 follows the ready input and status bit8 follows control bit16. Status bit3 means at least one free transmit place with bit16 clear, or at least four with bit16 set.
- R12: The receive queue holds 2*TX_DEPTH bytes. A sequencer push into a full receive queue is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | Write strobe (takes priority over read) |
| bus_rd | input | 1 | Read strobe; read side effects occur at the clock edge |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| irq | output | 1 | Interrupt request |
| cfg_ctrl | output | 32 | Stored control word |
| cfg_frames | output | 32 | Stored frame description |
| cfg_total_bytes | output | 32 | Upper count joined with frames bits 15:0 |
| seq_tx_pop | input | 1 | Sequencer takes one transmit byte |
| seq_tx_data | output | 8 | Head transmit byte |
| seq_tx_empty | output | 1 | Transmit queue empty |
| seq_rx_push | input | 1 | Sequencer delivers one receive byte |
| seq_rx_data | input | 8 | Receive byte |
| seq_tx_done | input | 1 | Transmit-complete pulse |
| seq_rx_done | input | 1 | Receive-complete pulse |
| seq_ready | input | 1 | Sequencer idle and ready |

## Verification
The hardest cases are the refusals made at the queue edges: a packed write when only two places are free, a packed read when three bytes wait, and a sequencer push into a full receive queue. None of these shows directly at the ports. The stimulus first brings each queue to the exact fill level through the byte registers. It then makes the refused access and drains the queue completely. The scoreboard of expected bytes shows whether anything was lost, added or reordered.

// File: rtl/qsb_pkg.sv
package qsb_pkg;

    localparam logic [7:0] OFS_CTRL   = 8'h00;
    localparam logic [7:0] OFS_FRAMES = 8'h04;
    localparam logic [7:0] OFS_IEN    = 8'h0C;
    localparam logic [7:0] OFS_STATUS = 8'h10;
    localparam logic [7:0] OFS_RXB    = 8'h40;
    localparam logic [7:0] OFS_TXB    = 8'h44;
    localparam logic [7:0] OFS_RXW    = 8'h48;
    localparam logic [7:0] OFS_TXW    = 8'h4C;
    localparam logic [7:0] OFS_UPPER  = 8'h50;

    localparam logic [31:0] CTRL_KEEP  = 32'h0F01_E403;
    localparam logic [31:0] UPPER_KEEP = 32'hFFFF_0000;
    localparam int          PACK_BIT   = 16;
    localparam int          NUM_EVT    = 3;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_CTRL, SEL_FRAMES, SEL_IEN, SEL_STATUS,
        SEL_RXB, SEL_TXB, SEL_RXW, SEL_TXW, SEL_UPPER
    } reg_sel_e;

    typedef struct packed {
        logic        rd;
        logic        wr;
        reg_sel_e    sel;
        logic [31:0] wdata;
    } bus_req_t;

    typedef struct packed {
        logic [22:0] zero_hi;
        logic        packed_mode;
        logic        ready;
        logic        zero_6;
        logic        tx_full;
        logic        rx_empty;
        logic        tx_space;
        logic [2:0]  evt;
    } status_t;

    function automatic reg_sel_e decode(input logic [7:0] a);
        case (a)
            OFS_CTRL:   return SEL_CTRL;
            OFS_FRAMES: return SEL_FRAMES;
            OFS_IEN:    return SEL_IEN;
            OFS_STATUS: return SEL_STATUS;
            OFS_RXB:    return SEL_RXB;
            OFS_TXB:    return SEL_TXB;
            OFS_RXW:    return SEL_RXW;
            OFS_TXW:    return SEL_TXW;
            OFS_UPPER:  return SEL_UPPER;
            default:    return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/qsb_fifo.sv
module qsb_fifo #(
    parameter int DEPTH = 8,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [2:0]    push_n,
    input  logic [31:0]   push_data,
    input  logic [2:0]    pop_n,
    output logic [31:0]   head,
    output logic [AW:0]   count
);
    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [AW:0]   free_slots, push_w, pop_w;
    logic          push_ok, pop_ok;

    assign free_slots = (AW+1)'(DEPTH) - count;
    assign push_w     = (AW+1)'(push_n);
    assign pop_w      = (AW+1)'(pop_n);
    assign push_ok    = (push_n != 3'd0) && (free_slots >= push_w);
    assign pop_ok     = (pop_n != 3'd0) && (count >= pop_w);

    generate
        for (genvar k = 0; k < 4; k++) begin : g_peek
            assign head[8*k +: 8] = mem[rd_ptr + AW'(k)];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) begin
                for (int k = 0; k < 4; k++) begin
                    if (k < int'(push_n)) begin
                        mem[wr_ptr + AW'(k)] <= push_data[8*k +: 8];
                    end
                end
                wr_ptr <= wr_ptr + AW'(push_n);
            end
            if (pop_ok) begin
                rd_ptr <= rd_ptr + AW'(pop_n);
            end
            count <= count + (push_ok ? push_w : '0) - (pop_ok ? pop_w : '0);
        end
    end

    // R6 / R12: occupancy never passes the depth
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
        count <= (AW+1)'(DEPTH));

    // R7: a refused pop with no push leaves the level unchanged
    a_r7_short_pop_holds: assert property (@(posedge clk) disable iff (rst)
        (pop_n != 3'd0 && count < pop_w && push_n == 3'd0) |=> $stable(count));

endmodule

// File: rtl/qsb_events.sv
module qsb_events #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_vec,
    input  logic [N-1:0] clr_vec,
    output logic [N-1:0] evt
);
    generate
        for (genvar i = 0; i < N; i++) begin : g_bit
            always_ff @(posedge clk) begin
                if (rst)             evt[i] <= 1'b0;
                else if (set_vec[i]) evt[i] <= 1'b1;
                else if (clr_vec[i]) evt[i] <= 1'b0;
            end

            // R8: a set bit not cleared by a write of 1 stays set
            a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
                (evt[i] && !clr_vec[i]) |=> evt[i]);

            // R9: a set request shows on the next cycle
            a_r9_set_seen: assert property (@(posedge clk) disable iff (rst)
                set_vec[i] |=> evt[i]);
        end
    endgenerate
endmodule

// File: rtl/qspi_bus_regs.sv
module qspi_bus_regs #(
    parameter int TX_DEPTH = 8,
    localparam int RX_DEPTH = 2 * TX_DEPTH,
    localparam int TAW = $clog2(TX_DEPTH),
    localparam int RAW = $clog2(RX_DEPTH)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq,
    output logic [31:0] cfg_ctrl,
    output logic [31:0] cfg_frames,
    output logic [31:0] cfg_total_bytes,
    input  logic        seq_tx_pop,
    output logic [7:0]  seq_tx_data,
    output logic        seq_tx_empty,
    input  logic        seq_rx_push,
    input  logic [7:0]  seq_rx_data,
    input  logic        seq_tx_done,
    input  logic        seq_rx_done,
    input  logic        seq_ready
);
    import qsb_pkg::*;

    bus_req_t    req;
    logic [31:0] ctrl_q, frames_q, upper_q;
    logic [5:0]  ien_q;
    logic [2:0]  tx_push_n, rx_pop_n;
    logic [31:0] tx_head, rx_head;
    logic [TAW:0] tx_count, tx_free;
    logic [RAW:0] rx_count;
    logic [2:0]  evt_set, evt_clr, evt;
    logic        packed_mode, rx_avail_cond;
    status_t     stat;

    always_comb begin
        req.wr    = bus_sel && bus_wr;
        req.rd    = bus_sel && bus_rd && !bus_wr;
        req.sel   = decode(bus_addr);
        req.wdata = bus_wdata;
    end

    // configuration registers
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            frames_q <= '0;
            upper_q  <= '0;
            ien_q    <= '0;
        end else if (req.wr) begin
            case (req.sel)
                SEL_CTRL:   ctrl_q   <= req.wdata & CTRL_KEEP;
                SEL_FRAMES: frames_q <= req.wdata;
                SEL_UPPER:  upper_q  <= req.wdata & UPPER_KEEP;
                SEL_IEN:    ien_q    <= req.wdata[5:0];
                default:    ;
            endcase
        end
    end

    assign packed_mode     = ctrl_q[PACK_BIT];
    assign cfg_ctrl        = ctrl_q;
    assign cfg_frames      = frames_q;
    assign cfg_total_bytes = {upper_q[31:16], frames_q[15:0]};

    // transmit queue: bus pushes, sequencer pops
    always_comb begin
        tx_push_n = 3'd0;
        if (req.wr && req.sel == SEL_TXB) tx_push_n = 3'd1;
        if (req.wr && req.sel == SEL_TXW) tx_push_n = 3'd4;
    end

    qsb_fifo #(.DEPTH(TX_DEPTH)) u_txq (
        .clk       (clk),
        .rst       (rst),
        .push_n    (tx_push_n),
        .push_data (req.wdata),
        .pop_n     (seq_tx_pop ? 3'd1 : 3'd0),
        .head      (tx_head),
        .count     (tx_count)
    );

    assign seq_tx_data  = tx_head[7:0];
    assign seq_tx_empty = (tx_count == '0);
    assign tx_free      = (TAW+1)'(TX_DEPTH) - tx_count;

    // receive queue: sequencer pushes, bus pops
    always_comb begin
        rx_pop_n = 3'd0;
        if (req.rd && req.sel == SEL_RXB) rx_pop_n = 3'd1;
        if (req.rd && req.sel == SEL_RXW) rx_pop_n = 3'd4;
    end

    qsb_fifo #(.DEPTH(RX_DEPTH)) u_rxq (
        .clk       (clk),
        .rst       (rst),
        .push_n    (seq_rx_push ? 3'd1 : 3'd0),
        .push_data ({24'h0, seq_rx_data}),
        .pop_n     (rx_pop_n),
        .head      (rx_head),
        .count     (rx_count)
    );

    // sticky events
    assign rx_avail_cond = packed_mode ? (rx_count >= (RAW+1)'(4))
                                       : (rx_count != '0);
    assign evt_set = {rx_avail_cond, seq_rx_done, seq_tx_done};
    assign evt_clr = (req.wr && req.sel == SEL_STATUS) ? req.wdata[2:0] : 3'b000;

    qsb_events #(.N(NUM_EVT)) u_evt (
        .clk     (clk),
        .rst     (rst),
        .set_vec (evt_set),
        .clr_vec (evt_clr),
        .evt     (evt)
    );

    always_comb begin
        stat             = '0;
        stat.evt         = evt;
        stat.tx_space    = packed_mode ? (tx_free >= (TAW+1)'(4)) : (tx_free != '0);
        stat.rx_empty    = (rx_count == '0);
        stat.tx_full     = (tx_count == (TAW+1)'(TX_DEPTH));
        stat.ready       = seq_ready;
        stat.packed_mode = packed_mode;
    end

    assign irq = |(stat[5:0] & ien_q);

    // read mux
    always_comb begin
        bus_rdata = '0;
        case (req.sel)
            SEL_CTRL:   bus_rdata = ctrl_q;
            SEL_FRAMES: bus_rdata = frames_q;
            SEL_IEN:    bus_rdata = {26'h0, ien_q};
            SEL_STATUS: bus_rdata = stat;
            SEL_UPPER:  bus_rdata = upper_q;
            SEL_RXB:    bus_rdata = (rx_count != '0) ? {24'h0, rx_head[7:0]} : '0;
            SEL_RXW:    bus_rdata = (rx_count >= (RAW+1)'(4)) ? rx_head : '0;
            default:    bus_rdata = '0;
        endcase
    end

    // R10: no interrupt without an enable
    a_r10_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
        irq |-> (ien_q != 6'd0));

    // R9: condition seen at a clock edge shows as RX available afterwards
    a_r9_avail_flag: assert property (@(posedge clk) disable iff (rst)
        rx_avail_cond |=> stat.evt[2]);

    // R3: a sequencer pop of a non-empty queue lowers its level unless the bus pushes
    a_r3_pop_drains: assert property (@(posedge clk) disable iff (rst)
        (seq_tx_pop && !seq_tx_empty && tx_push_n == 3'd0) |=> (tx_count == $past(tx_count) - 1'b1));

endmodule

// File: tb/qspi_bus_regs_test.sv
module qspi_bus_regs_test;

    localparam int TXD = 8;
    localparam int RXD = 2 * TXD;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 0, bus_wr = 0, bus_rd = 0;
    logic [7:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0;
    logic [31:0] bus_rdata;
    logic        irq;
    logic [31:0] cfg_ctrl, cfg_frames, cfg_total_bytes;
    logic        seq_tx_pop = 0;
    logic [7:0]  seq_tx_data;
    logic        seq_tx_empty;
    logic        seq_rx_push = 0;
    logic [7:0]  seq_rx_data = 0;
    logic        seq_tx_done = 0, seq_rx_done = 0, seq_ready = 0;

    int vectors = 0;
    int miscompares = 0;
    int tx_cnt = 0;
    int rx_cnt = 0;
    logic [7:0] tx_q[$];
    logic [7:0] rx_q[$];
    logic [31:0] rd;

    always #4 clk = ~clk;

    qspi_bus_regs #(.TX_DEPTH(TXD)) uut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
        .cfg_ctrl(cfg_ctrl), .cfg_frames(cfg_frames), .cfg_total_bytes(cfg_total_bytes),
        .seq_tx_pop(seq_tx_pop), .seq_tx_data(seq_tx_data), .seq_tx_empty(seq_tx_empty),
        .seq_rx_push(seq_rx_push), .seq_rx_data(seq_rx_data), .seq_tx_done(seq_tx_done),
        .seq_rx_done(seq_rx_done), .seq_ready(seq_ready)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        vectors++;
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s: got %08h expected %08h", req, got, exp);
        end
    endtask

    task automatic bwrite(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic bread(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_rd = 1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 0; bus_rd = 0;
    endtask

    // driver side of the transmit scoreboard
    task automatic put_tx_byte(input logic [7:0] b);
        if (tx_cnt < TXD) begin tx_q.push_back(b); tx_cnt++; end
        bwrite(8'h44, {24'h0, b});
    endtask

    task automatic put_tx_word(input logic [31:0] w);
        if (tx_cnt <= TXD - 4) begin
            for (int k = 0; k < 4; k++) tx_q.push_back(w[8*k +: 8]);
            tx_cnt += 4;
        end
        bwrite(8'h4C, w);
    endtask

    // monitor side of the transmit scoreboard
    task automatic drain_tx(input string req);
        while (tx_q.size() > 0) begin
            logic [7:0] e;
            e = tx_q.pop_front();
            @(negedge clk);
            chk({req, " tx order"}, {24'h0, seq_tx_data}, {24'h0, e});
            chk({req, " tx nonempty"}, {31'h0, seq_tx_empty}, 32'h0);
            seq_tx_pop = 1;
            @(negedge clk);
            seq_tx_pop = 0;
            tx_cnt--;
        end
        #1 chk({req, " tx empty at end"}, {31'h0, seq_tx_empty}, 32'h1);
    endtask

    task automatic push_rx(input logic [7:0] b);
        if (rx_cnt < RXD) begin rx_q.push_back(b); rx_cnt++; end
        @(negedge clk);
        seq_rx_push = 1; seq_rx_data = b;
        @(negedge clk);
        seq_rx_push = 0;
    endtask

    task automatic get_rx_byte(input string req);
        logic [31:0] e;
        e = 32'h0;
        if (rx_cnt > 0) begin e = {24'h0, rx_q.pop_front()}; rx_cnt--; end
        bread(8'h40, rd);
        chk(req, rd, e);
    endtask

    task automatic get_rx_word(input string req);
        logic [31:0] e;
        e = 32'h0;
        if (rx_cnt >= 4) begin
            for (int k = 0; k < 4; k++) e[8*k +: 8] = rx_q.pop_front();
            rx_cnt -= 4;
        end
        bread(8'h48, rd);
        chk(req, rd, e);
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        if (which == 0) seq_tx_done = 1; else seq_rx_done = 1;
        @(negedge clk);
        seq_tx_done = 0; seq_rx_done = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;

        // R1 reset state
        bread(8'h00, rd); chk("R1 ctrl", rd, 32'h0);
        bread(8'h04, rd); chk("R1 frames", rd, 32'h0);
        bread(8'h10, rd); chk("R1 status", rd, 32'h18);
        chk("R1 irq", {31'h0, irq}, 32'h0);

        // R2 register masks
        bwrite(8'h00, 32'hFFFF_FFFF);
        bread(8'h00, rd); chk("R2 ctrl mask", rd, 32'h0F01_E403);
        // R11 packed flag and ready mirrors
        bread(8'h10, rd); chk("R11 status packed", rd, 32'h118);
        seq_ready = 1;
        bread(8'h10, rd); chk("R11 status ready", rd, 32'h198);
        bwrite(8'h00, 32'h3);
        bwrite(8'h04, 32'hA5A5_1234);
        bread(8'h04, rd); chk("R2 frames", rd, 32'hA5A5_1234);
        bwrite(8'h50, 32'h1234_5678);
        bread(8'h50, rd); chk("R2 upper", rd, 32'h1234_0000);
        chk("R2 total", cfg_total_bytes, 32'h1234_1234);
        bwrite(8'h0C, 32'hFFFF_FFFF);
        bread(8'h0C, rd); chk("R2 ien", rd, 32'h3F);
        bwrite(8'h0C, 32'h0);

        // R3 R4 byte and packed writes share the queue
        put_tx_byte(8'h11);
        put_tx_byte(8'h22);
        put_tx_word(32'h4433_2A1B);
        put_tx_byte(8'h55);
        drain_tx("R3 R4");

        // R6 fill, full flag, drop on full
        for (int i = 0; i < TXD; i++) put_tx_byte(8'h80 + 8'(i));
        bread(8'h10, rd); chk("R6 tx full flag", rd & 32'h28, 32'h20);
        put_tx_byte(8'hEE);
        drain_tx("R6");

        // R4 packed write dropped when only two places are free
        for (int i = 0; i < TXD - 2; i++) put_tx_byte(8'h30 + 8'(i));
        put_tx_word(32'hDEAD_BEEF);
        drain_tx("R4 drop");

        // R11 TX space threshold in packed mode
        bwrite(8'h00, 32'h0001_0003);
        for (int i = 0; i < TXD - 3; i++) put_tx_byte(8'h60 + 8'(i));
        bread(8'h10, rd); chk("R11 tx space packed", rd & 32'h8, 32'h0);
        bwrite(8'h00, 32'h3);
        bread(8'h10, rd); chk("R11 tx space byte", rd & 32'h8, 32'h8);
        drain_tx("R11");

        // R5 R7 receive path
        for (int i = 0; i < 5; i++) push_rx(8'hC0 + 8'(i));
        get_rx_word("R5 packed read");
        get_rx_byte("R5 byte read");
        get_rx_byte("R7 empty byte read");
        bread(8'h10, rd); chk("R7 rx empty flag", rd & 32'h10, 32'h10);
        for (int i = 0; i < 3; i++) push_rx(8'hA0 + 8'(i));
        get_rx_word("R7 short packed read");
        for (int i = 0; i < 3; i++) get_rx_byte("R7 bytes kept");

        // R12 receive depth
        for (int i = 0; i < RXD + 1; i++) push_rx(8'(i * 7));
        for (int i = 0; i < RXD / 4; i++) get_rx_word("R12 full drain");
        get_rx_byte("R12 overflow dropped");

        // R9 RX available thresholds
        bwrite(8'h10, 32'h7);
        bwrite(8'h00, 32'h0001_0003);
        for (int i = 0; i < 3; i++) push_rx(8'h10 + 8'(i));
        bwrite(8'h10, 32'h4);
        bread(8'h10, rd); chk("R9 packed below four", rd & 32'h4, 32'h0);
        push_rx(8'h13);
        bread(8'h10, rd); chk("R9 packed at four", rd & 32'h4, 32'h4);
        get_rx_word("R9 drain");
        bwrite(8'h00, 32'h3);
        bwrite(8'h10, 32'h4);
        bread(8'h10, rd); chk("R9 cleared when empty", rd & 32'h4, 32'h0);
        push_rx(8'h77);
        bread(8'h10, rd); chk("R9 byte mode one", rd & 32'h4, 32'h4);
        get_rx_byte("R9 drain byte");
        bwrite(8'h10, 32'h4);

        // R8 sticky events and write-one-to-clear
        pulse(0);
        bread(8'h10, rd); chk("R8 tx done set", rd & 32'h7, 32'h1);
        pulse(1);
        bwrite(8'h10, 32'h2);
        bread(8'h10, rd); chk("R8 partial clear", rd & 32'h7, 32'h1);
        bwrite(8'h10, 32'h1);
        bread(8'h10, rd); chk("R8 cleared", rd & 32'h7, 32'h0);

        // R10 interrupt gating
        pulse(0);
        #1 chk("R10 no enable", {31'h0, irq}, 32'h0);
        bwrite(8'h0C, 32'h1);
        #1 chk("R10 enabled event", {31'h0, irq}, 32'h1);
        bwrite(8'h10, 32'h1);
        #1 chk("R10 event cleared", {31'h0, irq}, 32'h0);
        bwrite(8'h0C, 32'h8);
        #1 chk("R10 level enable", {31'h0, irq}, 32'h1);
        bwrite(8'h0C, 32'h0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule